// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ninth-Bit Address Filtering

This block receives asynchronous serial frames on a single input line. A free-running 16x oversampling tick sets its timing. It detects a falling start edge and confirms the start bit at mid-bit. It then shifts in 8 or 9 data bits LSB first, taking each one at the centre of its bit period, and checks the stop bit. Completed frames go into a two-entry receive buffer. Each entry holds the data byte, the ninth bit and a framing-error marker for that frame.

In 9-bit mode the receiver can act as a node on a multi-drop line. When address filtering is on, it keeps only frames whose ninth bit is 1, which marks them as addresses, and discards all others. The host reads the head entry through `data_o`, `bit9_o` and `ferr_o`, and pops it with a one-cycle `rd_i` pulse. `rdy_o` is the data-ready interrupt. A sticky overrun flag reports frames lost to a full buffer, and only disabling the receiver clears it.

Top module: `uart_addr_rx`

## Requirements
- R1: While `port_en_i` is low, the frame engine, the buffer and both error flags are cleared. One cycle after it goes low, `rdy_o` and `oerr_o` read 0.
- R2: In 8-bit mode (`nine_bit_i`=0), a frame of one low start bit, 8 data bits LSB first and one high stop bit appears on `data_o` with `bit9_o`=0. Each bit is sampled at mid-bit.
- R3: In 9-bit mode (`nine_bit_i`=1), the bit that follows the 8 data bits appears on `bit9_o` beside the byte on `data_o`.
- R4: While `rx_en_i` is low, a frame on the line leaves the buffer untouched.
- R5: With `nine_bit_i`=1 and `addr_det_i`=1, a frame whose ninth bit is 0 is discarded and `rdy_o` does not rise. A frame whose ninth bit is 1 is stored.
- R6: With `nine_bit_i`=1 and `addr_det_i`=0, every frame is stored, and its ninth bit is passed through unchanged.
- R7: In 8-bit mode, `addr_det_i` has no effect, so every frame is stored.
- R8: A stop bit sampled low marks that frame's entry with a framing error. `ferr_o` shows the marker of the head entry only, so it changes when a pop exposes the next entry.
- R9: The buffer holds two frames in arrival order. `rdy_o` stays high while it is non-empty, and a `rd_i` pulse pops the head.
- R10: A frame that completes while the buffer is full sets `oerr_o` and is dropped. While `oerr_o` is set, every completed frame is dropped and the stored entries are unchanged.
- R11: `oerr_o` stays set until `rx_en_i` is driven low. Reads do not clear it.
- R12: A low level that is gone at the mid-start sample (8 oversample ticks after detection) is rejected, and no frame results.
- R13: While the buffer is empty, `data_o`, `bit9_o` and `ferr_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling strobe, 16 per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| port_en_i | input | 1 | Port enable; low holds the block cleared |
| nine_bit_i | input | 1 | 1 selects 9-bit frames |
| rx_en_i | input | 1 | Receiver enable; low also clears overrun |
| addr_det_i | input | 1 | Ninth-bit address filter enable (9-bit mode only) |
| rd_i | input | 1 | Pop the head entry |
| data_o | output | 8 | Head entry data byte |
| bit9_o | output | 1 | Head entry ninth bit |
| ferr_o | output | 1 | Head entry framing error |
| oerr_o | output | 1 | Overrun flag |
| rdy_o | output | 1 | Data-ready interrupt, buffer non-empty |

## Verification
A sampling phase error in the frame engine shows up within one frame. The byte on `data_o` comes out shifted or bit-swapped at the first pop, and a stop bit read at the wrong time sets a false framing error. A wrong buffer pointer or count shows up at the second or third pop, either as a byte out of order or as `rdy_o` falling while a frame is still stored. A flaw in the overrun or address-filter decisions shows up the frame after the trigger: an entry that should have stayed fixed changes, `rdy_o` rises for a discarded frame, or `oerr_o` changes state in the cycle after a read or after `rx_en_i` toggles.

// File: rtl/rx_pkg.sv
package rx_pkg;
  parameter int unsigned RX_DATA_W = 8;

  typedef struct packed {
    logic                 ferr;
    logic                 b9;
    logic [RX_DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      tick_i,
  input  logic      rxd_i,
  input  logic      nine_i,
  output logic      done_o,
  output rx_entry_t entry_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned SH_W  = RX_DATA_W + 1;
  localparam int unsigned IDX_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [SH_W-1:0]  sh_q;
  logic             nine_q;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = nine_q ? IDX_W'(RX_DATA_W) : IDX_W'(RX_DATA_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      nine_q  <= 1'b0;
      done_o  <= 1'b0;
      entry_o <= '0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rxd_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            nine_q  <= nine_i;
          end
          ST_START: if (cnt_q == MID) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= rxd_i ? ST_IDLE : ST_DATA;  // glitch returns to idle
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: if (cnt_q == LAST) begin
            cnt_q <= '0;
            sh_q  <= {rxd_i, sh_q[SH_W-1:1]};
            if (idx_q == last_idx) state_q <= ST_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: if (cnt_q == LAST) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            entry_o.ferr <= !rxd_i;
            entry_o.b9   <= nine_q & sh_q[SH_W-1];
            entry_o.data <= nine_q ? sh_q[RX_DATA_W-1:0] : sh_q[SH_W-1:1];
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_buf.sv
module rx_buf
  import rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      push_i,
  input  rx_entry_t din_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic      empty_o,
  output logic      full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  rx_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_MAX) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_MAX) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[g] <= '0;
      else if (do_push && wr_q == PTR_W'(g)) mem_q[g] <= din_i;
    end
  end
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import rx_pkg::*;
#(
  parameter int unsigned OSR   = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  input  logic                 port_en_i,
  input  logic                 nine_bit_i,
  input  logic                 rx_en_i,
  input  logic                 addr_det_i,
  input  logic                 rd_i,
  output logic [RX_DATA_W-1:0] data_o,
  output logic                 bit9_o,
  output logic                 ferr_o,
  output logic                 oerr_o,
  output logic                 rdy_o
);
  logic      rxd_s, port_clr, eng_clr;
  logic      done, keep, push, full, empty;
  rx_entry_t frm, head;

  assign port_clr = !port_en_i;
  assign eng_clr  = port_clr || !rx_en_i;

  rx_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  rx_frame #(.OSR(OSR)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(eng_clr), .tick_i(tick_i),
    .rxd_i(rxd_s), .nine_i(nine_bit_i), .done_o(done), .entry_o(frm)
  );

  // address filter applies only in 9-bit mode
  assign keep = !(nine_bit_i && addr_det_i) || frm.b9;
  assign push = done && keep && !oerr_o && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            oerr_o <= 1'b0;
    else if (eng_clr)                       oerr_o <= 1'b0;
    else if (done && keep && full)          oerr_o <= 1'b1;
  end

  rx_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(port_clr), .push_i(push),
    .din_i(frm), .pop_i(rd_i), .head_o(head), .empty_o(empty), .full_o(full)
  );

  assign rdy_o  = !empty;
  assign data_o = empty ? '0 : head.data;
  assign bit9_o = !empty && head.b9;
  assign ferr_o = !empty && head.ferr;
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk
  import rx_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 rxd_i,
  input logic                 port_en_i,
  input logic                 nine_bit_i,
  input logic                 rx_en_i,
  input logic                 addr_det_i,
  input logic                 rd_i,
  input logic [RX_DATA_W-1:0] data_o,
  input logic                 bit9_o,
  input logic                 ferr_o,
  input logic                 oerr_o,
  input logic                 rdy_o
);
  assert_off_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> !rdy_o && !oerr_o);

  assert_rdy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o && !rd_i && port_en_i |=> rdy_o);

  assert_overrun_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oerr_o) |-> $past(rdy_o));

  assert_overrun_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oerr_o && rx_en_i && port_en_i && !rd_i |=>
      $stable(data_o) && $stable(bit9_o) && $stable(ferr_o));

  assert_oerr_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !oerr_o);

  assert_oerr_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oerr_o && rx_en_i && port_en_i |=> oerr_o);

  assert_empty_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> data_o == '0 && !bit9_o && !ferr_o);
endmodule

bind uart_addr_rx uart_addr_rx_chk u_chk (.*);

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;
  localparam int BIT_CLK = 64;  // 16 ticks of 4 clocks

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       port_en_i = 1'b0;
  logic       nine_bit_i = 1'b0;
  logic       rx_en_i = 1'b0;
  logic       addr_det_i = 1'b0;
  logic       rd_i;
  logic [7:0] data_o;
  logic       bit9_o, ferr_o, oerr_o, rdy_o;
  logic       rd_mon = 1'b0, rd_man = 1'b0, auto_rd = 1'b1;
  logic [1:0] tick_cnt = '0;
  logic [9:0] exp_q [$];
  int         n_chk = 0, n_bad = 0, cyc = 0;
  bit         ended = 1'b0;

  assign rd_i = rd_mon | rd_man;

  uart_addr_rx u_dut (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    tick_cnt <= tick_cnt + 1'b1;
    tick_i   <= (tick_cnt == 2'd3);
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // driver: bad_stop holds the stop bit low past its mid sample
  task automatic send(logic [7:0] d, logic b9, logic bad_stop, logic expect_it);
    if (expect_it) exp_q.push_back({bad_stop, nine_bit_i & b9, d});
    @(negedge clk_i) rxd_i = 1'b0;
    repeat (BIT_CLK) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      rxd_i = d[i];
      repeat (BIT_CLK) @(negedge clk_i);
    end
    if (nine_bit_i) begin
      rxd_i = b9;
      repeat (BIT_CLK) @(negedge clk_i);
    end
    if (bad_stop) begin
      rxd_i = 1'b0;
      repeat (48) @(negedge clk_i);
      rxd_i = 1'b1;
      repeat (16) @(negedge clk_i);
    end else begin
      rxd_i = 1'b1;
      repeat (BIT_CLK) @(negedge clk_i);
    end
    repeat (128) @(negedge clk_i);
  endtask

  task automatic man_pop(string req, logic [7:0] exp_d);
    @(negedge clk_i);
    check(req, data_o, exp_d);
    rd_man = 1'b1;
    @(negedge clk_i) rd_man = 1'b0;
  endtask

  // monitor: pops and compares against the scoreboard
  always @(negedge clk_i) begin
    if (rd_mon) rd_mon <= 1'b0;
    else if (auto_rd && rdy_o) begin
      if (exp_q.size() == 0) check("R4/R5 unexpected frame", {ferr_o, bit9_o, data_o}, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check("R2/R3/R6/R8 frame", {ferr_o, bit9_o, data_o}, e);
      end
      rd_mon <= 1'b1;
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=done", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R13 reset rdy", rdy_o, 0);
    check("R13 reset data", {ferr_o, bit9_o, data_o}, 0);
    check("R11 reset oerr", oerr_o, 0);
    port_en_i = 1'b1; rx_en_i = 1'b1;
    repeat (200) @(negedge clk_i);

    // R2 8-bit frames, R8 framing error follows its own entry
    send(8'hA5, 0, 0, 1);
    send(8'h3C, 0, 0, 1);
    send(8'h00, 0, 0, 1);
    send(8'hFF, 0, 0, 1);
    send(8'h55, 0, 1, 1);
    send(8'h81, 0, 0, 1);

    // R3 R6 9-bit, filter off
    nine_bit_i = 1'b1;
    send(8'h12, 0, 0, 1);
    send(8'h34, 1, 0, 1);

    // R5 filter on
    addr_det_i = 1'b1;
    send(8'h56, 0, 0, 0);
    check("R5 data frame dropped", rdy_o, 0);
    send(8'h78, 1, 0, 1);

    // R7 filter ignored in 8-bit mode
    nine_bit_i = 1'b0;
    send(8'h9A, 0, 0, 1);
    addr_det_i = 1'b0;

    // R4 receiver disabled
    rx_en_i = 1'b0;
    send(8'hC3, 0, 0, 0);
    check("R4 disabled rdy", rdy_o, 0);
    rx_en_i = 1'b1;
    repeat (20) @(negedge clk_i);

    // R12 start glitch
    rxd_i = 1'b0;
    repeat (12) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (300) @(negedge clk_i);
    check("R12 glitch rdy", rdy_o, 0);
    send(8'h6E, 0, 0, 1);
    repeat (10) @(negedge clk_i);
    check("R2 scoreboard drained", exp_q.size(), 0);

    // R9 R10 R11 overrun
    auto_rd = 1'b0;
    send(8'hA1, 0, 0, 0);
    send(8'hA2, 0, 0, 0);
    check("R9 two stored rdy", rdy_o, 1);
    check("R10 no overrun yet", oerr_o, 0);
    send(8'hA3, 0, 0, 0);
    check("R10 overrun set", oerr_o, 1);
    check("R10 head kept", data_o, 8'hA1);
    send(8'hA4, 0, 0, 0);
    check("R10 head kept after more", data_o, 8'hA1);
    man_pop("R9 pop order first", 8'hA1);
    check("R9 next head", data_o, 8'hA2);
    check("R11 oerr survives read", oerr_o, 1);
    send(8'hA5, 0, 0, 0);
    check("R10 dropped while overrun", data_o, 8'hA2);
    check("R10 still one entry", rdy_o, 1);
    @(negedge clk_i) rx_en_i = 1'b0;
    @(negedge clk_i) rx_en_i = 1'b1;
    @(negedge clk_i);
    check("R11 oerr cleared", oerr_o, 0);
    check("R11 entry kept", data_o, 8'hA2);
    man_pop("R9 pop order second", 8'hA2);
    check("R9 empty rdy", rdy_o, 0);
    check("R13 empty data", data_o, 0);

    // R1 port disable clears buffer
    send(8'h5A, 0, 0, 0);
    check("R1 pre-disable rdy", rdy_o, 1);
    @(negedge clk_i) port_en_i = 1'b0;
    @(negedge clk_i);
    check("R1 disabled rdy", rdy_o, 0);
    check("R1 disabled oerr", oerr_o, 0);
    port_en_i = 1'b1;
    auto_rd = 1'b1;
    send(8'hE7, 0, 0, 1);
    repeat (10) @(negedge clk_i);
    check("R1 recovered, scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule